// File: doc/BRIEF.md
# Dual-Direction Bus Register Transceiver

This block moves an 18-bit word between two ports, A and B, through one storage element per direction. Each direction has its own latch-enable, capture clock and output enable. Three data-flow modes are available in each direction. With latch-enable high the storage tracks the input port, so the block is transparent. With latch-enable low and the capture clock falling, the storage takes a new word, so the block acts as a flip-flop. With latch-enable low and the capture clock quiet, the storage holds its word.

The capture clocks and latch-enables are not used as clocks. A free-running system clock samples them. A capture-clock falling edge is recognised when the previous sample is high and the current sample is low. The data inputs are sampled in the same cycle as the controls, so a captured word is the one present when the clock was seen low.

Pads are modelled as separate input, output and enable vectors. The A-to-B output enable is active high and the B-to-A output enable is active low. A port that is not enabled reports a low enable and a zero data word. The two directions never interact.

Top module: `ubrt_xcvr`

## Requirements
- R1: A synchronous active-high reset clears both stored words to zero. It also clears the sampled controls and the capture-clock history to low.
- R2: While the A-to-B latch-enable is high, `b_out` shows the `a_in` value from two system clock edges earlier (when B is enabled).
- R3: While the A-to-B latch-enable is low and its capture clock does not fall, the stored A-to-B word does not change.
- R4: With the A-to-B latch-enable low, a high-to-low change of `ck_ab` loads the stored word with the `a_in` value present when `ck_ab` first reads low. The new word is visible on `b_out` two edges after that sample.
- R5: A low-to-high change of a capture clock loads nothing.
- R6: `b_oe` equals `oe_ab` (active high) with no clock delay. When `b_oe` is 0, `b_out` is all zeros.
- R7: `a_oe` is the inverse of `oe_ba_n` (active low) with no clock delay. When `a_oe` is 0, `a_out` is all zeros.
- R8: The B-to-A direction follows R2 to R5 with `b_in`, `le_ba`, `ck_ba` and `a_out`.
- R9: When a latch-enable drops, the stored word keeps the last value taken while it was high.
- R10: The two directions are independent. Activity in one never changes the other's stored word or outputs, including when both ports are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | free-running system clock |
| rst | input | 1 | synchronous active-high reset |
| a_in | input | 18 | word arriving at port A |
| le_ab | input | 1 | A-to-B latch-enable, high = transparent |
| ck_ab | input | 1 | A-to-B capture clock, loads on falling edge |
| oe_ab | input | 1 | A-to-B output enable, active high |
| b_out | output | 18 | word driven at port B |
| b_oe | output | 1 | port B drive enable |
| b_in | input | 18 | word arriving at port B |
| le_ba | input | 1 | B-to-A latch-enable, high = transparent |
| ck_ba | input | 1 | B-to-A capture clock, loads on falling edge |
| oe_ba_n | input | 1 | B-to-A output enable, active low |
| a_out | output | 18 | word driven at port A |
| a_oe | output | 1 | port A drive enable |

## Verification
A data word or latch-enable change applied before edge n is sampled at edge n and stored at edge n+1. It is therefore checked on the falling clock half after edge n+1. A capture-clock fall is seen one edge later than the sample that reads it low, and its data lands on that same later edge. The output enables are combinational, so they are checked a fraction of a nanosecond after they change. A cycle-level reference model in the bench steps on the same edges as the design and is compared on every falling edge during the random phase. Directed checks wait exactly the stated number of edges before sampling.

// File: rtl/ubrt_pkg.sv
package ubrt_pkg;
   localparam int unsigned UBRT_WIDTH = 18;

   typedef enum logic {
      OE_ACT_HIGH = 1'b0,
      OE_ACT_LOW  = 1'b1
   } oe_pol_e;
endpackage

// File: rtl/ubrt_sense.sv
module ubrt_sense #(
   parameter int unsigned W = ubrt_pkg::UBRT_WIDTH
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   input  logic         le,
   input  logic         ck,
   output logic [W-1:0] din_q,
   output logic         le_q,
   output logic         fall
);
   if (W < 1) begin : g_bad_width
      $error("ubrt_sense: W must be at least 1");
   end

   logic ck_cur;
   logic ck_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         din_q   <= '0;
         le_q    <= 1'b0;
         ck_cur  <= 1'b0;
         ck_prev <= 1'b0;
      end else begin
         din_q   <= din;
         le_q    <= le;
         ck_cur  <= ck;
         ck_prev <= ck_cur;
      end
   end

   assign fall = ck_prev & ~ck_cur;

   AST_FALL_ONE: assert property (@(posedge clk) disable iff (rst)
      fall |=> !fall); // R5
endmodule

// File: rtl/ubrt_store.sv
module ubrt_store #(
   parameter int unsigned W    = ubrt_pkg::UBRT_WIDTH,
   parameter logic [W-1:0] INIT = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] q_r;

   always_ff @(posedge clk) begin
      if (rst)       q_r <= INIT;
      else if (load) q_r <= d;
   end

   assign q = q_r;

   AST_HOLD: assert property (@(posedge clk) disable iff (rst)
      !load |=> $stable(q_r)); // R3
   AST_LOAD: assert property (@(posedge clk) disable iff (rst)
      load |=> q_r == $past(d)); // R2
endmodule

// File: rtl/ubrt_drive.sv
module ubrt_drive #(
   parameter int unsigned      W   = ubrt_pkg::UBRT_WIDTH,
   parameter ubrt_pkg::oe_pol_e POL = ubrt_pkg::OE_ACT_HIGH
) (
   input  logic         oe_pin,
   input  logic [W-1:0] q,
   output logic [W-1:0] dout,
   output logic         doe
);
   logic en;

   if (POL == ubrt_pkg::OE_ACT_HIGH) begin : g_high
      assign en = oe_pin;
   end else begin : g_low
      assign en = ~oe_pin;
   end

   assign doe  = en;
   assign dout = en ? q : '0;
endmodule

// File: rtl/ubrt_lane.sv
module ubrt_lane #(
   parameter int unsigned       W   = ubrt_pkg::UBRT_WIDTH,
   parameter ubrt_pkg::oe_pol_e POL = ubrt_pkg::OE_ACT_HIGH
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] din,
   input  logic         le,
   input  logic         ck,
   input  logic         oe_pin,
   output logic [W-1:0] dout,
   output logic         doe
);
   logic [W-1:0] din_q;
   logic         le_q;
   logic         fall;
   logic [W-1:0] q;

   ubrt_sense #(.W(W)) u_sense (
      .clk(clk), .rst(rst), .din(din), .le(le), .ck(ck),
      .din_q(din_q), .le_q(le_q), .fall(fall)
   );

   ubrt_store #(.W(W)) u_store (
      .clk(clk), .rst(rst), .load(le_q | fall), .d(din_q), .q(q)
   );

   ubrt_drive #(.W(W), .POL(POL)) u_drive (
      .oe_pin(oe_pin), .q(q), .dout(dout), .doe(doe)
   );
endmodule

// File: rtl/ubrt_xcvr.sv
module ubrt_xcvr #(
   parameter int unsigned W = ubrt_pkg::UBRT_WIDTH
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] a_in,
   input  logic         le_ab,
   input  logic         ck_ab,
   input  logic         oe_ab,
   output logic [W-1:0] b_out,
   output logic         b_oe,
   input  logic [W-1:0] b_in,
   input  logic         le_ba,
   input  logic         ck_ba,
   input  logic         oe_ba_n,
   output logic [W-1:0] a_out,
   output logic         a_oe
);
   if (W < 1 || W > 1024) begin : g_bad_width
      $error("ubrt_xcvr: W out of range");
   end

   ubrt_lane #(.W(W), .POL(ubrt_pkg::OE_ACT_HIGH)) u_ab (
      .clk(clk), .rst(rst), .din(a_in), .le(le_ab), .ck(ck_ab),
      .oe_pin(oe_ab), .dout(b_out), .doe(b_oe)
   );

   ubrt_lane #(.W(W), .POL(ubrt_pkg::OE_ACT_LOW)) u_ba (
      .clk(clk), .rst(rst), .din(b_in), .le(le_ba), .ck(ck_ba),
      .oe_pin(oe_ba_n), .dout(a_out), .doe(a_oe)
   );

   AST_B_QUIET: assert property (@(posedge clk) disable iff (rst)
      !b_oe |-> b_out == '0); // R6
   AST_B_POL: assert property (@(posedge clk) disable iff (rst)
      !oe_ab |-> !b_oe); // R6
   AST_A_POL: assert property (@(posedge clk) disable iff (rst)
      oe_ba_n |-> !a_oe); // R7
   AST_A_QUIET: assert property (@(posedge clk) disable iff (rst)
      !a_oe |-> a_out == '0); // R7
endmodule

// File: tb/ubrt_xcvr_test.sv
module ubrt_xcvr_test;
   localparam int W = 18;
   localparam int LIMIT = 20000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [W-1:0] a_in = '0, b_in = '0;
   logic le_ab = 0, ck_ab = 0, oe_ab = 1, le_ba = 0, ck_ba = 0, oe_ba_n = 0;
   logic [W-1:0] b_out, a_out;
   logic b_oe, a_oe;

   int checks = 0;
   int fails  = 0;
   bit done = 0;

   always #4 clk = ~clk;

   ubrt_xcvr #(.W(W)) uut (
      .clk(clk), .rst(rst), .a_in(a_in), .le_ab(le_ab), .ck_ab(ck_ab),
      .oe_ab(oe_ab), .b_out(b_out), .b_oe(b_oe), .b_in(b_in), .le_ba(le_ba),
      .ck_ba(ck_ba), .oe_ba_n(oe_ba_n), .a_out(a_out), .a_oe(a_oe)
   );

   // reference model built from the requirements
   logic [W-1:0] m_dab, m_sab, m_dba, m_sba;
   logic m_leab, m_c1ab, m_c2ab, m_leba, m_c1ba, m_c2ba;

   always @(posedge clk) begin
      if (rst) begin
         m_dab <= '0; m_sab <= '0; m_leab <= 0; m_c1ab <= 0; m_c2ab <= 0;
         m_dba <= '0; m_sba <= '0; m_leba <= 0; m_c1ba <= 0; m_c2ba <= 0;
      end else begin
         m_dab <= a_in; m_leab <= le_ab; m_c1ab <= ck_ab; m_c2ab <= m_c1ab;
         if (m_leab || (m_c2ab && !m_c1ab)) m_sab <= m_dab;
         m_dba <= b_in; m_leba <= le_ba; m_c1ba <= ck_ba; m_c2ba <= m_c1ba;
         if (m_leba || (m_c2ba && !m_c1ba)) m_sba <= m_dba;
      end
   end

   function automatic logic [W-1:0] exp_out(input logic en, input logic [W-1:0] s);
      return en ? s : '0;
   endfunction

   task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(LIMIT * 8);
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   initial begin
      void'($urandom(32'd2024));
      step(3);
      rst = 0;
      step(2);
      check("R1 b_out after reset", b_out, '0);
      check("R1 a_out after reset", a_out, '0);

      le_ab = 1; a_in = 18'h2A5C3;
      step(2);
      check("R2 transparent first", b_out, 18'h2A5C3);
      a_in = 18'h15A3C;
      step(2);
      check("R2 transparent second", b_out, 18'h15A3C);

      le_ab = 0; a_in = 18'h3FFFF;
      step(3);
      check("R9 keeps last transparent", b_out, 18'h15A3C);

      ck_ab = 1; a_in = 18'h00F0F;
      step(3);
      check("R5 rising edge ignored", b_out, 18'h15A3C);

      ck_ab = 0; a_in = 18'h0BEEF;
      step(2);
      check("R4 falling edge capture", b_out, 18'h0BEEF);
      a_in = 18'h11111;
      step(4);
      check("R3 hold with quiet clock", b_out, 18'h0BEEF);

      oe_ab = 0; #1;
      check("R6 b_oe low", {17'd0, b_oe}, '0);
      check("R6 b_out zero when off", b_out, '0);
      oe_ab = 1; #1;
      check("R6 b_oe high", {17'd0, b_oe}, 18'd1);
      check("R6 stored word survives disable", b_out, 18'h0BEEF);

      le_ba = 1; b_in = 18'h2C0DE;
      step(2);
      check("R8 B-to-A transparent", a_out, 18'h2C0DE);
      check("R10 B side untouched", b_out, 18'h0BEEF);
      le_ba = 0; ck_ba = 1; b_in = 18'h00001;
      step(2);
      ck_ba = 0; b_in = 18'h0CAFE;
      step(2);
      check("R8 B-to-A falling capture", a_out, 18'h0CAFE);
      oe_ba_n = 1; #1;
      check("R7 a_oe low", {17'd0, a_oe}, '0);
      check("R7 a_out zero when off", a_out, '0);
      oe_ba_n = 0; #1;
      check("R7 a_oe high", {17'd0, a_oe}, 18'd1);

      for (int i = 0; i < 3000; i++) begin
         check("R4 random B port", b_out, exp_out(oe_ab, m_sab));
         check("R8 random A port", a_out, exp_out(!oe_ba_n, m_sba));
         check("R6 random b_oe", {17'd0, b_oe}, {17'd0, oe_ab});
         check("R7 random a_oe", {17'd0, a_oe}, {17'd0, !oe_ba_n});
         a_in = W'($urandom); b_in = W'($urandom);
         le_ab = ($urandom % 4) == 0; le_ba = ($urandom % 4) == 0;
         if ($urandom % 3 == 0) ck_ab = ~ck_ab;
         if ($urandom % 3 == 0) ck_ba = ~ck_ba;
         oe_ab = ($urandom % 4) != 0; oe_ba_n = ($urandom % 4) == 0;
         step(1);
      end

      rst = 1;
      step(1);
      rst = 0; #1;
      check("R1 B port after late reset", b_out, exp_out(oe_ab, '0));
      check("R1 A port after late reset", a_out, exp_out(!oe_ba_n, '0));
      summary();
   end
endmodule